// File: doc/BRIEF.md
# Ultrasonic measurement power-up sequencer

This block runs one ultrasonic flow measurement each time software pulses a start strobe. A single cycle counter starts at the start strobe. Programmable marks on that counter turn on, in order, the bias supply, the high-speed PLL, the pulse generator, the high-speed sampling converter with its clock, and the data-acquisition window. In the ultra-low-power mode the PLL stays off for a programmed hold-off interval while the transducers and the front end settle. In the normal mode the PLL comes up together with bias. Once the acquisition window has run its programmed length, the enables fall one per cycle in reverse order. A one-cycle completion interrupt follows, and the block returns to idle.

Bias control comes from two configuration sets. Set A drives bias while the PLL is off, and set B drives it once the PLL runs. A selector output shows which set is live. The masked bias bits must agree between the two sets, and a sticky flag records any disagreement seen at the handover. The sequencer rejects a start whose marks are out of order. It ignores a start that arrives while a measurement is already running and records the event.

Top module: `meas_powerup_seq`

## Requirements
- R1: With `ulpMode`=1 at an accepted start, `pllEn` stays low for cycles 0 to `holdCnt`-1 and rises in cycle `holdCnt`. Cycle 0 is the cycle right after the clock edge that samples the start, and `biasEn` is high from cycle 0.
- R2: With `ulpMode`=0 at an accepted start, `pllEn` rises in cycle 0 together with `biasEn`, and `holdCnt` has no effect on timing or on validity.
- R3: `pulseEn` rises in cycle `markA`, `adcEn` in cycle `markB` and `acqEn` in cycle `markD`. All three stay high until the shutdown.
- R4: `acqEn` is high for exactly `acqLen` cycles, which are cycles `markD` to `markD`+`acqLen`-1.
- R5: After acquisition, one enable drops per cycle in this order: acq, converter, pulse, PLL, bias. The next cycle has `doneIrq` high for one cycle with every enable low and `busy` high. `busy` is low in the cycle after that.
- R6: A start is accepted only when eff_hold ≤ `markA` ≤ `markB` ≤ `markD` and `acqLen` ≠ 0, where eff_hold is `holdCnt` in ulp mode and 0 otherwise. A rejected start pulses `cfgErr` for one cycle, and the block stays idle with all enables low.
- R7: `bankSel` equals `pllEn` and is low while idle. `biasCfg` shows `cfgSetB` when `bankSel` is 1 and `cfgSetA` otherwise.
- R8: `mismatchErr` is set when `bankSel` rises while `cfgSetA` and `cfgSetB` differ in any bit of BIAS_MASK (default 0x0F). Differences outside the mask do not set it. Once set, it holds until reset.
- R9: A start strobe while `busy` is high has no effect on the running sequence and sets the sticky `overrun` flag.
- R10: Mode, hold-off, marks and length are captured at the accepted start. Later changes to these inputs do not alter the running sequence.
- R11: After reset, every enable, `doneIrq`, `busy`, `bankSel` and every error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Start strobe, one cycle |
| ulpMode | input | 1 | 1 selects the hold-off with the PLL held off |
| holdCnt | input | CNT_W | Hold-off length in cycles |
| markA | input | CNT_W | Pulse start mark |
| markB | input | CNT_W | Converter enable mark |
| markD | input | CNT_W | Acquisition start mark |
| acqLen | input | CNT_W | Acquisition length in cycles |
| cfgSetA | input | CFG_W | Control set used while the PLL is off |
| cfgSetB | input | CFG_W | Control set used while the PLL runs |
| biasCfg | output | CFG_W | Selected control set |
| bankSel | output | 1 | Active set selector (1 = set B) |
| biasEn | output | 1 | Bias enable |
| pllEn | output | 1 | High-speed PLL enable |
| pulseEn | output | 1 | Pulse generation enable |
| adcEn | output | 1 | Sampling converter and clock enable |
| acqEn | output | 1 | Data acquisition enable |
| doneIrq | output | 1 | Completion interrupt, one cycle |
| busy | output | 1 | Sequence in progress |
| cfgErr | output | 1 | Start rejected for bad ordering or zero length |
| overrun | output | 1 | Sticky: start seen while busy |
| mismatchErr | output | 1 | Sticky: bias bits differed at set handover |

## Verification
The assertions check the structural rules on every cycle. The pulse generator needs the PLL, the PLL needs bias, and acquisition needs the converter. The interrupt comes with all enables low. In ulp mode the PLL is off at the first bias cycle, and in normal mode it is on. The error flags stay sticky, and a start while busy sets overrun. Only the bench scenarios can show the exact cycle of each mark and the acquisition length. The same holds for the reverse-order shutdown timing, the capture of the configuration at start, the rejection of each bad ordering, and the masked comparison that leaves differences outside the mask unflagged.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_SHUT,
    ST_IRQ
  } seqState_t;

  // number of enables: bias, pll, pulse, adc, acq (index order)
  localparam int N_EN = 5;
  // marks compared against the counter: hold, A, B, D
  localparam int N_MARK = N_EN - 1;
  localparam int STEP_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              advance;
    logic              running;
    logic              shutting;
    logic [STEP_W-1:0] shutStep;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic cfgValid;
    logic acqLast;
  } seqStat_t;

endpackage

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import meas_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startStb,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     busy,
  output logic     doneIrq,
  output logic     cfgErr,
  output logic     overrun
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_EN - 1);

  seqState_t         state;
  logic [STEP_W-1:0] step;
  logic              startOk;

  assign startOk = (state == ST_IDLE) && startStb && stat.cfgValid;

  always_comb begin
    cmd.capture  = startOk;
    cmd.advance  = (state == ST_RUN) && !stat.acqLast;
    cmd.running  = (state == ST_RUN);
    cmd.shutting = (state == ST_SHUT);
    cmd.shutStep = step;
  end

  assign busy    = (state != ST_IDLE);
  assign doneIrq = (state == ST_IRQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          step <= '0;
          if (startOk) state <= ST_RUN;
        end
        ST_RUN: begin
          if (stat.acqLast) begin
            state <= ST_SHUT;
            step  <= '0;
          end
        end
        ST_SHUT: begin
          if (step == LAST_STEP) begin
            state <= ST_IRQ;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgErr  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      cfgErr  <= (state == ST_IDLE) && startStb && !stat.cfgValid;
      overrun <= overrun | (busy && startStb);
    end
  end

endmodule

// File: rtl/meas_seq_dp.sv
module meas_seq_dp
  import meas_seq_pkg::*;
#(
  parameter int              CNT_W     = 16,
  parameter int              CFG_W     = 8,
  parameter logic [CFG_W-1:0] BIAS_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic             ulpMode,
  input  logic [CNT_W-1:0] holdCnt,
  input  logic [CNT_W-1:0] markA,
  input  logic [CNT_W-1:0] markB,
  input  logic [CNT_W-1:0] markD,
  input  logic [CNT_W-1:0] acqLen,
  input  logic [CFG_W-1:0] cfgSetA,
  input  logic [CFG_W-1:0] cfgSetB,
  output seqStat_t         stat,
  output logic [N_EN-1:0]  enVec,
  output logic             bankSel,
  output logic [CFG_W-1:0] biasCfg,
  output logic             mismatchErr
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] effHold;
  logic [CNT_W-1:0] markLive [N_MARK];
  logic [CNT_W-1:0] markQ    [N_MARK];
  logic [EXT_W-1:0] endQ;
  logic [EXT_W-1:0] cnt;
  logic [N_MARK-1:0] reached;
  logic             selPrev;

  // ordering check on the live inputs, used only to accept a start
  assign effHold     = ulpMode ? holdCnt : '0;
  assign markLive[0] = effHold;
  assign markLive[1] = markA;
  assign markLive[2] = markB;
  assign markLive[3] = markD;

  logic [N_MARK-2:0] orderOk;
  for (genvar k = 0; k < N_MARK - 1; k++) begin : g_order
    assign orderOk[k] = (markLive[k] <= markLive[k+1]);
  end

  assign stat.cfgValid = (&orderOk) && (acqLen != '0);
  assign stat.acqLast  = (cnt == endQ);

  // captured configuration
  for (genvar m = 0; m < N_MARK; m++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            markQ[m] <= '0;
      else if (cmd.capture) markQ[m] <= markLive[m];
    end
    assign reached[m] = (cnt >= {1'b0, markQ[m]});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endQ <= '0;
    end else if (cmd.capture) begin
      endQ <= {1'b0, markD} + {1'b0, acqLen} - EXT_W'(1);
    end
  end

  // cycle counter since the accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.capture) cnt <= '0;
    else if (cmd.advance) cnt <= cnt + 1'b1;
  end

  // enable decode: rise at marks while running, fall in reverse order
  for (genvar j = 0; j < N_EN; j++) begin : g_en
    localparam logic [STEP_W-1:0] OFF_STEP = STEP_W'(N_EN - 1 - j);
    logic runOn;
    if (j == 0) begin : g_first
      assign runOn = 1'b1;
    end else begin : g_rest
      assign runOn = reached[j-1];
    end
    assign enVec[j] = (cmd.running && runOn) ||
                      (cmd.shutting && (cmd.shutStep < OFF_STEP));
  end

  // control set handover follows the PLL enable
  assign bankSel = enVec[1];
  assign biasCfg = bankSel ? cfgSetB : cfgSetA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev     <= 1'b0;
      mismatchErr <= 1'b0;
    end else begin
      selPrev     <= bankSel;
      mismatchErr <= mismatchErr |
                     (bankSel && !selPrev && (|((cfgSetA ^ cfgSetB) & BIAS_MASK)));
    end
  end

endmodule

// File: rtl/meas_powerup_seq.sv
module meas_powerup_seq
  import meas_seq_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               CFG_W     = 8,
  parameter logic [CFG_W-1:0] BIAS_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             ulpMode,
  input  logic [CNT_W-1:0] holdCnt,
  input  logic [CNT_W-1:0] markA,
  input  logic [CNT_W-1:0] markB,
  input  logic [CNT_W-1:0] markD,
  input  logic [CNT_W-1:0] acqLen,
  input  logic [CFG_W-1:0] cfgSetA,
  input  logic [CFG_W-1:0] cfgSetB,
  output logic [CFG_W-1:0] biasCfg,
  output logic             bankSel,
  output logic             biasEn,
  output logic             pllEn,
  output logic             pulseEn,
  output logic             adcEn,
  output logic             acqEn,
  output logic             doneIrq,
  output logic             busy,
  output logic             cfgErr,
  output logic             overrun,
  output logic             mismatchErr
);

  seqCmd_t         cmd;
  seqStat_t        stat;
  logic [N_EN-1:0] enVec;

  meas_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stat     (stat),
    .cmd      (cmd),
    .busy     (busy),
    .doneIrq  (doneIrq),
    .cfgErr   (cfgErr),
    .overrun  (overrun)
  );

  meas_seq_dp #(
    .CNT_W     (CNT_W),
    .CFG_W     (CFG_W),
    .BIAS_MASK (BIAS_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .ulpMode     (ulpMode),
    .holdCnt     (holdCnt),
    .markA       (markA),
    .markB       (markB),
    .markD       (markD),
    .acqLen      (acqLen),
    .cfgSetA     (cfgSetA),
    .cfgSetB     (cfgSetB),
    .stat        (stat),
    .enVec       (enVec),
    .bankSel     (bankSel),
    .biasCfg     (biasCfg),
    .mismatchErr (mismatchErr)
  );

  assign biasEn  = enVec[0];
  assign pllEn   = enVec[1];
  assign pulseEn = enVec[2];
  assign adcEn   = enVec[3];
  assign acqEn   = enVec[4];

endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic             ulpMode,
  input logic [CNT_W-1:0] holdCnt,
  input logic             biasEn,
  input logic             pllEn,
  input logic             pulseEn,
  input logic             adcEn,
  input logic             acqEn,
  input logic             doneIrq,
  input logic             busy,
  input logic             bankSel,
  input logic             cfgErr,
  input logic             overrun,
  input logic             mismatchErr
);

  AST_PLL_NEEDS_BIAS: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> biasEn); // R1

  AST_ULP_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(biasEn) && $past(ulpMode) && ($past(holdCnt) != '0)) |-> !pllEn); // R1

  AST_NORMAL_PLL_ON: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(biasEn) && !$past(ulpMode)) |-> pllEn); // R2

  AST_PULSE_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rstN)
    pulseEn |-> pllEn); // R3

  AST_ACQ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    acqEn |-> (adcEn && pulseEn)); // R3

  AST_ADC_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    adcEn |-> pulseEn); // R3

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (busy && !biasEn && !pllEn && !pulseEn && !adcEn && !acqEn)); // R5

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> (!doneIrq && !busy)); // R5

  AST_BIAS_LAST_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(biasEn) |-> $past(!pllEn)); // R5

  AST_CFG_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!busy && !biasEn)); // R6

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !bankSel); // R7

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    mismatchErr |=> mismatchErr); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startStb) |=> overrun); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R9

endmodule

bind meas_powerup_seq meas_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startStb    (startStb),
  .ulpMode     (ulpMode),
  .holdCnt     (holdCnt),
  .biasEn      (biasEn),
  .pllEn       (pllEn),
  .pulseEn     (pulseEn),
  .adcEn       (adcEn),
  .acqEn       (acqEn),
  .doneIrq     (doneIrq),
  .busy        (busy),
  .bankSel     (bankSel),
  .cfgErr      (cfgErr),
  .overrun     (overrun),
  .mismatchErr (mismatchErr)
);

// File: tb/meas_powerup_seq_tb.sv
module meas_powerup_seq_tb;

  localparam int CNT_W = 16;
  localparam int CFG_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0;
  logic ulpMode = 1'b0;
  logic [CNT_W-1:0] holdCnt = '0, markA = '0, markB = '0, markD = '0, acqLen = '0;
  logic [CFG_W-1:0] cfgSetA = '0, cfgSetB = '0;
  logic [CFG_W-1:0] biasCfg;
  logic bankSel, biasEn, pllEn, pulseEn, adcEn, acqEn, doneIrq, busy;
  logic cfgErr, overrun, mismatchErr;

  int vecCnt = 0;
  int errCnt = 0;

  always #5 clk = ~clk;

  meas_powerup_seq u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .ulpMode(ulpMode),
    .holdCnt(holdCnt), .markA(markA), .markB(markB), .markD(markD),
    .acqLen(acqLen), .cfgSetA(cfgSetA), .cfgSetB(cfgSetB),
    .biasCfg(biasCfg), .bankSel(bankSel), .biasEn(biasEn), .pllEn(pllEn),
    .pulseEn(pulseEn), .adcEn(adcEn), .acqEn(acqEn), .doneIrq(doneIrq),
    .busy(busy), .cfgErr(cfgErr), .overrun(overrun), .mismatchErr(mismatchErr)
  );

  // vector bits: {sel, busy, irq, acq, adc, pulse, pll, bias}
  typedef struct packed {
    logic [7:0]       vec;
    logic [CFG_W-1:0] cfg;
  } item_t;

  item_t expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string reqOf(input logic [7:0] d);
    if (d[1] || d[0]) return "R1/R2 pll-bias";
    if (d[2] || d[3]) return "R3 pulse-adc";
    if (d[4]) return "R4 acq";
    if (d[5] || d[6]) return "R5 irq-busy";
    return "R7 sel";
  endfunction

  // monitor: pop and compare one expected item per cycle
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      item_t e;
      logic [7:0] act;
      e = expQ.pop_front();
      act = {bankSel, busy, doneIrq, acqEn, adcEn, pulseEn, pllEn, biasEn};
      vecCnt++;
      if (act != e.vec) begin
        errCnt++;
        $display("FAIL %s actual=%b expected=%b at %0t", reqOf(act ^ e.vec), act, e.vec, $time);
      end
      vecCnt++;
      if (biasCfg != e.cfg) begin
        errCnt++;
        $display("FAIL R7 biasCfg actual=%h expected=%h at %0t", biasCfg, e.cfg, $time);
      end
    end
  end

  // driver: start one measurement and push its whole expected trace
  task automatic runMeas(input bit ulp, input int hold, input int ta, input int tb,
                         input int td, input int len, input int ovAt, input bit scramble);
    int last;
    @(negedge clk);
    ulpMode = ulp; holdCnt = CNT_W'(hold); markA = CNT_W'(ta);
    markB = CNT_W'(tb); markD = CNT_W'(td); acqLen = CNT_W'(len);
    startStb = 1'b1;
    @(posedge clk);
    last = td + len;
    for (int c = 0; c <= last + 6; c++) begin
      item_t it;
      logic bi, pl, pu, ad, aq, ir, bu;
      if (c < last) begin
        bi = 1; pl = !ulp || (c >= hold); pu = c >= ta; ad = c >= tb;
        aq = c >= td; ir = 0; bu = 1;
      end else if (c < last + 5) begin
        int s;
        s = c - last;
        bi = s < 4; pl = s < 3; pu = s < 2; ad = s < 1; aq = 0; ir = 0; bu = 1;
      end else if (c == last + 5) begin
        bi = 0; pl = 0; pu = 0; ad = 0; aq = 0; ir = 1; bu = 1;
      end else begin
        bi = 0; pl = 0; pu = 0; ad = 0; aq = 0; ir = 0; bu = 0;
      end
      it.vec = {pl, bu, ir, aq, ad, pu, pl, bi};
      it.cfg = pl ? cfgSetB : cfgSetA;
      expQ.push_back(it);
    end
    #1 startStb = 1'b0;
    if (scramble) begin // R10: change everything after capture
      ulpMode = ~ulp; holdCnt = 16'd1; markA = 16'd1; markB = 16'd2;
      markD = 16'd3; acqLen = 16'd40;
    end
    if (ovAt >= 0) begin // R9: start while busy
      repeat (ovAt) @(negedge clk);
      startStb = 1'b1;
      @(posedge clk);
      #1 startStb = 1'b0;
    end
    wait (expQ.size() == 0);
    @(posedge clk);
  endtask

  task automatic badStart(input bit ulp, input int hold, input int ta, input int tb,
                          input int td, input int len);
    @(negedge clk);
    ulpMode = ulp; holdCnt = CNT_W'(hold); markA = CNT_W'(ta);
    markB = CNT_W'(tb); markD = CNT_W'(td); acqLen = CNT_W'(len);
    startStb = 1'b1;
    @(posedge clk);
    #1 startStb = 1'b0;
    @(negedge clk);
    check(cfgErr == 1'b1, "R6 cfgErr pulse", cfgErr, 1);
    check(busy == 1'b0 && biasEn == 1'b0, "R6 stays idle", {busy, biasEn}, 0);
    @(negedge clk);
    check(cfgErr == 1'b0, "R6 cfgErr single cycle", cfgErr, 0);
    check(busy == 1'b0, "R6 still idle", busy, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({bankSel, biasEn, pllEn, pulseEn, adcEn, acqEn, doneIrq, busy} == 8'h00,
          "R11 outputs in reset", {bankSel, biasEn, pllEn, pulseEn, adcEn, acqEn, doneIrq, busy}, 0);
    check({cfgErr, overrun, mismatchErr} == 3'b000, "R11 flags in reset",
          {cfgErr, overrun, mismatchErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && biasEn == 1'b0, "R11 idle after reset", {busy, biasEn}, 0);

    cfgSetA = 8'h35; cfgSetB = 8'hC5; // differ only outside the bias mask
    // R2: normal mode, hold ignored even though hold > markA
    runMeas(1'b0, 7, 3, 6, 9, 4, -1, 1'b0);
    // R1, R3, R4, R5, R7: ulp hold-off
    runMeas(1'b1, 5, 8, 12, 15, 3, -1, 1'b0);
    check(mismatchErr == 1'b0, "R8 unmasked difference ignored", mismatchErr, 0);
    // R3 boundary: all marks at zero, single-cycle acquisition
    runMeas(1'b1, 0, 0, 0, 0, 1, -1, 1'b0);
    // R10: inputs scrambled after capture
    runMeas(1'b1, 4, 6, 9, 11, 2, -1, 1'b1);
    check(overrun == 1'b0, "R9 no overrun yet", overrun, 0);
    // R9: start strobe during the run
    runMeas(1'b0, 0, 2, 4, 20, 5, 8, 1'b0);
    check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    // R6: rejected orderings
    badStart(1'b0, 0, 5, 3, 9, 2);  // markA > markB
    badStart(1'b0, 0, 2, 4, 9, 0);  // zero length
    badStart(1'b1, 6, 5, 7, 9, 2);  // hold > markA in ulp mode
    badStart(1'b0, 0, 2, 9, 8, 2);  // markB > markD
    // R8: masked bias bits differ at handover
    cfgSetA = 8'h01; cfgSetB = 8'h02;
    runMeas(1'b1, 3, 4, 5, 6, 2, -1, 1'b0);
    check(mismatchErr == 1'b1, "R8 mismatch set", mismatchErr, 1);
    repeat (3) @(negedge clk);
    check(mismatchErr == 1'b1, "R8 mismatch sticky", mismatchErr, 1);
    summary();
    $finish;
  end

endmodule